// File: doc/BRIEF.md
# Bitplane Tile Pixel Plotter

This block draws single pixels into a frame buffer that is organised as 8x8 tiles whose colour bits are split across interleaved bitplane bytes. The frame buffer lives in an external byte-wide RAM that has one cycle of read latency. A plot strobe takes the current x coordinate, which the block holds itself, together with the y coordinate, a colour register, an option register and a colour-depth select. The block then updates the two, four or eight plane bytes that hold that pixel. Each plane byte gets one read-modify-write, so every other bit in the byte is left unchanged.

Tiles are arranged column-major. Within one column of tiles they follow each other down the screen, and the number of tile rows per column comes from the screen height. Sprite mode fixes the height at 256 lines. The plotter can apply a checkerboard dither, which picks between the two nibbles of the colour register. It can also treat a zero colour as transparent, in which case the write is skipped. After every accepted plot, x advances by one, so a run of strobes draws a horizontal span.

Top module: `bitplane_plotter`

## Requirements
- R1: During and right after a synchronous reset, `busy` is low, `x_coord` is 0 and neither RAM enable is asserted.
- R2: For plane p, the RAM address is BASE_ADDR + ((x>>3)·ROWS + (y>>3))·TB + 2·(y&7) + OFF(p), taken modulo 2^ADDR_W. ROWS is SCREEN_H/8, or 32 in sprite mode. TB is 16, 32 or 64 bytes for `depth_sel` = 0, 1 or 2/3.
- R3: In each plane byte, only the bit under the mask 0x80>>(x&7) may change. It becomes 1 when colour bit p is 1 and 0 when colour bit p is 0.
- R4: The number of planes is 2 for `depth_sel`=0, 4 for `depth_sel`=1, and 8 for `depth_sel`=2 or 3. OFF(p) = 16·(p>>1) + (p&1), so the offsets are 0x00, 0x01, 0x10, 0x11, 0x20, 0x21, 0x30, 0x31. Plane p takes colour bit p.
- R5: Dither is on when `plot_opt[1]` is 1 and the depth is 2-bit or 4-bit. Then the colour is `colour_reg[7:4]` when (x XOR y)&1 is 1, and `colour_reg[3:0]` otherwise. In 8-bit depth the full `colour_reg` is always used.
- R6: When `plot_opt[0]` is 0 and bits 3:0 of the selected colour are all zero, the plot makes no RAM access and `busy` stays low.
- R7: In 8-bit depth with `plot_opt[4]`=1, the skip of R6 happens only when the whole colour byte is zero.
- R8: Every accepted strobe advances `x_coord` by one, with 8-bit wrap, whether or not the write is skipped.
- R9: `plot_opt[4]`=1 selects sprite mode, in which ROWS is 32 whatever SCREEN_H is.
- R10: Each plane takes one read cycle followed by one write cycle to the same address. `busy` is high for exactly 2·planes cycles, starting the cycle after the accepting edge. A strobe that arrives while `busy` is high is ignored.
- R11: When `x_load` and an accepted strobe fall in the same cycle, the plot uses `x_load_val` and `x_coord` becomes `x_load_val`+1. A load on its own sets `x_coord` to `x_load_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_load | input | 1 | Load the x register |
| x_load_val | input | 8 | Value for the x register |
| y_coord | input | 8 | Pixel y coordinate |
| colour_reg | input | 8 | Colour register |
| plot_opt | input | 8 | Options: bit0 opaque, bit1 dither, bit4 sprite / full-byte transparency |
| depth_sel | input | 2 | 0: 2-bit, 1: 4-bit, 2/3: 8-bit |
| plot_go | input | 1 | Plot strobe |
| x_coord | output | 8 | Current x coordinate |
| busy | output | 1 | Plane updates in progress |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_rd_en | output | 1 | RAM read; data returns the next cycle |
| mem_rdata | input | 8 | RAM read data |
| mem_wr_en | output | 1 | RAM write |
| mem_wdata | output | 8 | RAM write data |

## Verification
An x load and a plot strobe can land in the same cycle. In that case the plot must use the loaded coordinate and the register must step past it. The bench sets up this case directly, checks the pixel position and the new x value against explicit values, and then sets it up again at random in a long mixed run. A second overlap is a strobe that arrives while plane updates are still in flight. The bench issues such strobes back to back, and the cycle-level model, which counts the busy window, requires that they change neither x nor memory.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    localparam int OPT_OPAQUE = 0;
    localparam int OPT_DITHER = 1;
    localparam int OPT_SPRITE = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] colour;
        logic [2:0] last_plane;
    } plot_job_t;

    typedef struct packed {
        logic [7:0] colour;
        logic       skip;
    } colour_pick_t;

    // log2 of planes/2: tile bytes = 16 << depth_shift
    function automatic logic [1:0] depth_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [2:0] last_plane_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // plane pairs sit 16 bytes apart, the two planes of a pair are adjacent
    function automatic logic [7:0] plane_offset(input logic [2:0] p);
        return {2'b00, p[2:1], 3'b000, p[0]};
    endfunction

    function automatic logic [7:0] pixel_mask(input logic [2:0] xl);
        return 8'h80 >> xl;
    endfunction

endpackage

// File: rtl/bpp_addr_gen.sv
module bpp_addr_gen
    import bpp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int COORD_W   = 8,
    parameter int SCREEN_H  = 128,
    parameter int BASE_ADDR = 0
) (
    input  logic [COORD_W-1:0] x_pos,
    input  logic [COORD_W-1:0] y_pos,
    input  logic [1:0]         depth_sel,
    input  logic               sprite,
    output logic [ADDR_W-1:0]  base_addr
);
    localparam int ROWS_NORMAL = SCREEN_H / 8;
    localparam int ROWS_SPRITE = 256 / 8;

    logic [ADDR_W-1:0] rows;
    logic [ADDR_W-1:0] tile_idx;
    logic [ADDR_W-1:0] tile_off;
    logic [2:0]        tile_shift;

    always_comb begin
        rows       = sprite ? ADDR_W'(ROWS_SPRITE) : ADDR_W'(ROWS_NORMAL);
        tile_idx   = ADDR_W'(x_pos[COORD_W-1:3]) * rows + ADDR_W'(y_pos[COORD_W-1:3]);
        tile_shift = 3'd4 + {1'b0, depth_shift(depth_sel)};
        tile_off   = tile_idx << tile_shift;
        base_addr  = ADDR_W'(BASE_ADDR) + tile_off + ADDR_W'({y_pos[2:0], 1'b0});
    end
endmodule

// File: rtl/bpp_colour_sel.sv
module bpp_colour_sel
    import bpp_pkg::*;
(
    input  logic [7:0]   colour_reg,
    input  logic [7:0]   plot_opt,
    input  logic [1:0]   depth_sel,
    input  logic         parity,
    output colour_pick_t pick
);
    logic wide;
    logic [7:0] c;

    always_comb begin
        wide = depth_sel[1];
        if (!wide && plot_opt[OPT_DITHER] && parity)
            c = {4'h0, colour_reg[7:4]};
        else
            c = colour_reg;
        pick.colour = c;
        if (plot_opt[OPT_OPAQUE])
            pick.skip = 1'b0;
        else if (wide && plot_opt[OPT_SPRITE])
            pick.skip = (c == 8'h00);
        else
            pick.skip = (c[3:0] == 4'h0);
    end
endmodule

// File: rtl/bpp_plane_seq.sv
module bpp_plane_seq
    import bpp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  plot_job_t         job,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata
);
    seq_state_e        st;
    logic [2:0]        plane;
    plot_job_t         job_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            plane  <= '0;
            job_q  <= '0;
            base_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        job_q  <= job;
                        base_q <= base_addr;
                        plane  <= '0;
                        st     <= ST_READ;
                    end
                end
                ST_READ: st <= ST_WRITE;
                ST_WRITE: begin
                    if (plane == job_q.last_plane) begin
                        st <= ST_IDLE;
                    end else begin
                        plane <= plane + 3'd1;
                        st    <= ST_READ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != ST_IDLE);
        mem_addr  = base_q + ADDR_W'(plane_offset(plane));
        mem_rd_en = (st == ST_READ);
        mem_wr_en = (st == ST_WRITE);
        if (job_q.colour[plane])
            mem_wdata = mem_rdata | job_q.mask;
        else
            mem_wdata = mem_rdata & ~job_q.mask;
    end
endmodule

// File: rtl/bitplane_plotter.sv
module bitplane_plotter
    import bpp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SCREEN_H  = 128,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x_load,
    input  logic [7:0]        x_load_val,
    input  logic [7:0]        y_coord,
    input  logic [7:0]        colour_reg,
    input  logic [7:0]        plot_opt,
    input  logic [1:0]        depth_sel,
    input  logic              plot_go,
    output logic [7:0]        x_coord,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata
);
    localparam int COORD_W = 8;

    logic [COORD_W-1:0] x_q;
    logic [COORD_W-1:0] x_eff;
    logic               accept;
    logic [ADDR_W-1:0]  base_addr;
    colour_pick_t       pick;
    plot_job_t          job;
    logic               seq_busy;

    assign x_eff  = x_load ? x_load_val : x_q;
    assign accept = plot_go && !seq_busy;

    always_ff @(posedge clk) begin
        if (rst)
            x_q <= '0;
        else if (accept)
            x_q <= x_eff + 8'd1;
        else if (x_load)
            x_q <= x_load_val;
    end

    bpp_addr_gen #(
        .ADDR_W(ADDR_W), .COORD_W(COORD_W),
        .SCREEN_H(SCREEN_H), .BASE_ADDR(BASE_ADDR)
    ) u_addr (
        .x_pos(x_eff), .y_pos(y_coord), .depth_sel(depth_sel),
        .sprite(plot_opt[OPT_SPRITE]), .base_addr(base_addr)
    );

    bpp_colour_sel u_col (
        .colour_reg(colour_reg), .plot_opt(plot_opt), .depth_sel(depth_sel),
        .parity(x_eff[0] ^ y_coord[0]), .pick(pick)
    );

    always_comb begin
        job.mask       = pixel_mask(x_eff[2:0]);
        job.colour     = pick.colour;
        job.last_plane = last_plane_of(depth_sel);
    end

    bpp_plane_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .start(accept && !pick.skip),
        .base_addr(base_addr), .job(job),
        .busy(seq_busy),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    assign busy    = seq_busy;
    assign x_coord = x_q;
endmodule

// File: rtl/bpp_plot_checker.sv
module bpp_plot_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              x_load,
    input logic [7:0]        x_load_val,
    input logic              plot_go,
    input logic [7:0]        x_coord,
    input logic              busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic [7:0]        mem_rdata,
    input logic              mem_wr_en,
    input logic [7:0]        mem_wdata
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!busy && x_coord == 8'd0)); // R1
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> mem_wr_en); // R10
    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> $past(mem_rd_en)); // R10
    AST_WR_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> mem_addr == $past(mem_addr)); // R2
    AST_WR_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> $countones(mem_wdata ^ mem_rdata) <= 1); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_rd_en && !mem_wr_en)); // R6
    AST_X_STEP: assert property (@(posedge clk) disable iff (rst) (plot_go && !busy && !x_load) |=> x_coord == $past(x_coord) + 8'd1); // R8
    AST_LOAD_PLOT: assert property (@(posedge clk) disable iff (rst) (plot_go && !busy && x_load) |=> x_coord == $past(x_load_val) + 8'd1); // R11
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst) (busy && !x_load) |=> x_coord == $past(x_coord)); // R10
endmodule

bind bitplane_plotter bpp_plot_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .x_load(x_load), .x_load_val(x_load_val),
    .plot_go(plot_go), .x_coord(x_coord), .busy(busy), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata)
);

// File: tb/bitplane_plotter_test.sv
`timescale 1ns/1ps
module bitplane_plotter_test;
    localparam int AW = 16;
    localparam int MSZ = 1 << AW;

    logic clk = 0;
    logic rst = 1;
    logic x_load = 0;
    logic [7:0] x_load_val = 0, y_coord = 0, colour_reg = 0, plot_opt = 0;
    logic [1:0] depth_sel = 0;
    logic plot_go = 0;
    logic [7:0] x_coord;
    logic busy;
    logic [AW-1:0] mem_addr;
    logic mem_rd_en, mem_wr_en;
    logic [7:0] mem_rdata = 0, mem_wdata;

    logic [7:0] dut_mem [MSZ];
    logic [7:0] ref_mem [MSZ];

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int mx = 0;
    int mcnt = 0;
    bit model_on = 0;

    always #5 clk = ~clk;

    bitplane_plotter #(.ADDR_W(AW), .SCREEN_H(128), .BASE_ADDR(0)) uut (
        .clk(clk), .rst(rst), .x_load(x_load), .x_load_val(x_load_val),
        .y_coord(y_coord), .colour_reg(colour_reg), .plot_opt(plot_opt),
        .depth_sel(depth_sel), .plot_go(plot_go), .x_coord(x_coord), .busy(busy),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // RAM with one cycle of read latency
    always @(posedge clk) begin
        if (mem_wr_en) dut_mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= dut_mem[mem_addr];
    end

    function automatic int ref_addr(int x, int y, int d, int opt, int p);
        int rows = ((opt >> 4) & 1) ? 32 : 16;
        int tb = (d == 0) ? 16 : (d == 1) ? 32 : 64;
        int off = (p / 2) * 16 + (p % 2);
        return ((((x / 8) * rows + (y / 8)) * tb) + (y % 8) * 2 + off) % MSZ;
    endfunction

    // behavioural reference, advanced on every clock edge
    always @(posedge clk) begin
        int old, xe, c, np, a, yy, d, opt;
        bit skip;
        if (rst) begin
            mx = 0; mcnt = 0;
        end else begin
            old = mcnt;
            if (old > 0) mcnt = old - 1;
            if (plot_go && old == 0) begin
                xe = x_load ? int'(x_load_val) : mx;
                yy = int'(y_coord); d = int'(depth_sel); opt = int'(plot_opt);
                c = int'(colour_reg);
                if (d < 2 && ((opt >> 1) & 1) && (((xe ^ yy) & 1) == 1)) c = c >> 4;
                if (opt & 1) skip = 0;
                else if (d >= 2 && ((opt >> 4) & 1)) skip = (c == 0);
                else skip = ((c & 15) == 0);
                mx = (xe + 1) % 256;
                if (!skip) begin
                    np = (d == 0) ? 2 : (d == 1) ? 4 : 8;
                    mcnt = 2 * np;
                    for (int p = 0; p < np; p++) begin
                        a = ref_addr(xe, yy, d, opt, p);
                        if ((c >> p) & 1) ref_mem[a] = ref_mem[a] | (8'h80 >> (xe % 8));
                        else ref_mem[a] = ref_mem[a] & ~(8'h80 >> (xe % 8));
                    end
                end
            end else if (x_load) begin
                mx = int'(x_load_val);
            end
        end
    end

    // per-cycle comparison against the model (R8, R10, R11)
    always @(negedge clk) begin
        if (model_on && !rst) begin
            checks++;
            if (x_coord !== mx[7:0] || busy !== (mcnt != 0)) begin
                errors++;
                $display("FAIL R8/R10/R11 cycle %0d: x=%0d busy=%0b expected x=%0d busy=%0b",
                         cyc, x_coord, busy, mx, (mcnt != 0));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check_byte(input int a, input logic [7:0] exp, input string tag);
        checks++;
        if (dut_mem[a] !== exp) begin
            errors++;
            $display("FAIL %s: mem[%0d]=%h expected %h", tag, a, dut_mem[a], exp);
        end
    endtask

    task automatic check_x(input logic [7:0] exp, input string tag);
        checks++;
        if (x_coord !== exp) begin
            errors++;
            $display("FAIL %s: x=%0d expected %0d", tag, x_coord, exp);
        end
    endtask

    task automatic do_plot(input logic ld, input logic [7:0] lv, input logic [7:0] y,
                           input logic [7:0] col, input logic [7:0] opt,
                           input logic [1:0] d, input bit wait_done);
        @(negedge clk);
        x_load = ld; x_load_val = lv; y_coord = y; colour_reg = col;
        plot_opt = opt; depth_sel = d; plot_go = 1;
        @(negedge clk);
        plot_go = 0; x_load = 0;
        if (wait_done) while (busy) @(negedge clk);
    endtask

    initial begin
        int bad;
        for (int i = 0; i < MSZ; i++) begin dut_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (busy !== 0 || x_coord !== 0 || mem_rd_en !== 0 || mem_wr_en !== 0) begin
            errors++;
            $display("FAIL R1: busy=%0b x=%0d rd=%0b wr=%0b expected 0 0 0 0",
                     busy, x_coord, mem_rd_en, mem_wr_en);
        end
        rst = 0;
        model_on = 1;

        // R2/R3: 2-bit pixel at origin, colour 3
        do_plot(1, 8'd0, 8'd0, 8'h03, 8'h01, 2'd0, 1);
        check_byte(0, 8'h80, "R2 plane0 origin");
        check_byte(1, 8'h80, "R3 plane1 origin");
        check_x(8'd1, "R8 after first plot");
        // R3: colour 1 at x=1 sets plane0 bit6 and clears plane1 bit6
        do_plot(0, 8'd0, 8'd0, 8'h01, 8'h01, 2'd0, 1);
        check_byte(0, 8'hC0, "R3 set bit");
        check_byte(1, 8'h80, "R3 clear bit keeps others");
        // R6/R8: transparent skip still advances x
        do_plot(0, 8'd0, 8'd0, 8'h10, 8'h00, 2'd0, 1);
        check_byte(0, 8'hC0, "R6 skipped write");
        check_x(8'd3, "R8 x after skip");
        // R5: dither, x=3 odd parity uses high nibble 2
        do_plot(0, 8'd0, 8'd0, 8'h21, 8'h03, 2'd0, 1);
        check_byte(0, 8'hC0, "R5 high nibble plane0");
        check_byte(1, 8'h90, "R5 high nibble plane1");
        // R5: x=4 even parity uses low nibble 1
        do_plot(0, 8'd0, 8'd0, 8'h21, 8'h03, 2'd0, 1);
        check_byte(0, 8'hC8, "R5 low nibble plane0");
        // R2/R4: 4-bit at x=8,y=9
        do_plot(1, 8'd8, 8'd9, 8'h0F, 8'h01, 2'd1, 1);
        check_byte(546, 8'h80, "R4 4bit off 0x00");
        check_byte(547, 8'h80, "R4 4bit off 0x01");
        check_byte(562, 8'h80, "R4 4bit off 0x10");
        check_byte(563, 8'h80, "R4 4bit off 0x11");
        // R9/R4: 8-bit sprite mode x=9,y=2 colour A5
        do_plot(1, 8'd9, 8'd2, 8'hA5, 8'h11, 2'd2, 1);
        check_byte(2052, 8'h40, "R9 sprite plane0");
        check_byte(2053, 8'h00, "R4 plane1");
        check_byte(2068, 8'h40, "R4 plane2");
        check_byte(2085, 8'h40, "R4 plane5");
        check_byte(2101, 8'h40, "R4 plane7");
        check_byte(2100, 8'h00, "R4 plane6");
        // R7: 8-bit with full-byte rule writes colour 0x10
        do_plot(1, 8'd0, 8'd0, 8'h10, 8'h10, 2'd2, 1);
        check_byte(32, 8'h80, "R7 full-byte rule writes plane4");
        // R6: same colour without bit4 is skipped
        do_plot(1, 8'd1, 8'd0, 8'h10, 8'h00, 2'd2, 1);
        check_byte(32, 8'h80, "R6 nibble rule skips");
        // R10: strobe while busy is ignored
        do_plot(1, 8'd20, 8'd0, 8'h03, 8'h01, 2'd0, 0);
        do_plot(0, 8'd0, 8'd0, 8'h03, 8'h01, 2'd0, 1);
        check_x(8'd21, "R10 busy strobe ignored");
        // R11: load and plot in the same cycle
        do_plot(1, 8'd40, 8'd0, 8'h03, 8'h01, 2'd0, 1);
        check_x(8'd41, "R11 load+plot x");
        check_byte(1280, 8'h80, "R11 load+plot pixel");

        // mixed random run
        void'($urandom(7));
        for (int i = 0; i < 400; i++) begin
            logic [7:0] o;
            o = 8'($urandom) & 8'h13;
            do_plot(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), o,
                    2'($urandom), ($urandom % 4) != 0);
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);

        // R2-R7: full memory agrees with the model
        bad = 0;
        for (int i = 0; i < MSZ; i++) if (dut_mem[i] !== ref_mem[i]) bad++;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R2 memory image: %0d mismatching bytes expected 0", bad);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule